// File: doc/BRIEF.md
# Master-Mode Serial Audio Transmitter

This block turns a stream of PCM sample words into a serial audio stream for a codec that takes its clocks from this block. It runs from an audio master clock at a fixed multiple of the sample rate, 256 by default. It divides that clock down to a bit clock and builds the frame sync from the same counters. The codec therefore only listens to the bit clock, the frame sync and the data line.

Samples enter through a plain write strobe into an eight-entry first-in first-out buffer. A level request tells an external DMA engine to refill the buffer once the fill level drops to a programmable threshold. In the default two-channel format, each frame carries a left word and then a right word, 16 bits each. The frame sync is low for the left word and high for the right word. It changes one bit clock ahead of each word's most significant bit.

A network option packs several channel words into one frame on the same data line. In that mode a one-bit-clock sync pulse marks the frame boundary. Sticky flags report an empty buffer at word-load time and a format change in mid-frame. A one-cycle pulse marks the start of every word.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset the bit clock, frame sync, data line, word-start pulse and both error flags are low, `fifo_empty` is high and `fifo_full` is low.
- R2: In two-channel mode the bit clock period is 8 master-clock cycles (256/(2*16)). Each bit period starts with the bit clock low for its first half. The data line changes only while the bit clock is low, and never while it stays high.
- R3: In two-channel mode a frame is 32 bits: the left word in bit slots 0-15, then the right word in slots 16-31, each sent most significant bit first. The frame sync is low from the last bit of the right word through the second-to-last bit of the left word. It is high from the last bit of the left word through the second-to-last bit of the right word.
- R4: The buffer holds 8 words and sends them in write order. `fifo_full` is high with 8 words stored and `fifo_empty` is high with none. A write while full is dropped.
- R5: `dma_req` is high exactly when the stored word count is less than or equal to `watermark` (3 bits, 0 to 7).
- R6: `word_start` is high for one master-clock cycle, while the bit clock is low, at the start of every word slot, including a slot filled with zeros.
- R7: When a word slot starts with the buffer empty, that word is sent as all zeros and `fifo_err` is set. It stays set until a cycle with `fifo_err_clr` high; a new error in that same cycle wins over the clear.
- R8: With `tdm_en` high, a frame holds 4 words of 16 bits (slot k in bits 16k to 16k+15) and the bit clock period is 4 master-clock cycles (256/64). The frame sync is high only during the last bit of the frame.
- R9: If `tdm_en` differs from the running format at any point other than the last master cycle of a frame, `sync_err` is set. The frame then restarts at bit 0 in the new format, loading a fresh word. `sync_err` stays set until a cycle with `sync_err_clr` high.
- R10: While `tx_en` is low, from the next master-clock edge on, the bit clock, frame sync and data line are held low. The next enable starts a frame at bit 0 with a left (slot 0) word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock (256 x sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| tdm_en | input | 1 | Select the multi-slot network format |
| wr_valid | input | 1 | Write strobe for one sample word |
| wr_data | input | 16 | Sample word to store |
| watermark | input | 3 | Fill level at or below which a refill is requested |
| fifo_err_clr | input | 1 | Clears the underrun flag |
| sync_err_clr | input | 1 | Clears the sync error flag |
| bclk | output | 1 | Bit clock to the codec |
| fsync | output | 1 | Frame sync to the codec |
| sdata | output | 1 | Serial data to the codec |
| dma_req | output | 1 | Refill request |
| fifo_full | output | 1 | Buffer holds 8 words |
| fifo_empty | output | 1 | Buffer holds no words |
| word_start | output | 1 | One-cycle pulse at each word start |
| fifo_err | output | 1 | Sticky underrun flag |
| sync_err | output | 1 | Sticky frame-format fault flag |

## Verification
A wrong bit or frame counter shows up on the very next bit-clock edges as a sync edge in the wrong place or a period of the wrong length. The bench measures both on every captured bit. A wrong read pointer or count shows within one frame as words out of write order, or as zeros and an underrun flag while words are still stored. A stuck flag or request shows at once against the counts the bench keeps itself. A mode latch that misses an update shows as a bit clock period that does not change after the mid-frame restart.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;
   typedef enum logic {
      FMT_STEREO = 1'b0,
      FMT_TDM    = 1'b1
   } tx_fmt_e;
endpackage

// File: rtl/atx_fifo.sv
`timescale 1ns/1ps
module atx_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         full,
   output logic                         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];
   assign level   = cnt;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= nxt(wr_ptr);
         if (do_pop)  rd_ptr <= nxt(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/atx_timing.sv
`timescale 1ns/1ps
module atx_timing
   import audio_tx_pkg::*;
#(
   parameter int SW        = 16,
   parameter int RATIO     = 256,
   parameter int TDM_SLOTS = 4,
   parameter bit TDM_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tdm_en,
   output logic run,
   output logic bclk,
   output logic fsync,
   output logic load,
   output logic shift,
   output logic fault
);
   localparam int ST_BITS  = 2 * SW;
   localparam int TD_BITS  = TDM_SLOTS * SW;
   localparam int ST_DIV   = RATIO / ST_BITS;
   localparam int TD_DIV   = RATIO / TD_BITS;
   localparam int MAX_BITS = (ST_BITS > TD_BITS) ? ST_BITS : TD_BITS;
   localparam int MAX_DIV  = (ST_DIV > TD_DIV) ? ST_DIV : TD_DIV;
   localparam int BW       = $clog2(MAX_BITS);
   localparam int CW       = $clog2(MAX_DIV);
   localparam int SWW      = $clog2(SW);

   tx_fmt_e       mode, req_mode;
   logic [CW-1:0] divcnt, div_last, div_half;
   logic [BW-1:0] bitpos, bit_last, next_bit;
   logic          bit_end, word_end, frame_end, start;

   generate
      if (TDM_EN) begin : g_tdm
         assign req_mode = tdm_en ? FMT_TDM : FMT_STEREO;
      end else begin : g_stereo_only
         assign req_mode = FMT_STEREO;
      end
   endgenerate

   assign div_last  = (mode == FMT_TDM) ? CW'(TD_DIV - 1)  : CW'(ST_DIV - 1);
   assign div_half  = (mode == FMT_TDM) ? CW'(TD_DIV / 2)  : CW'(ST_DIV / 2);
   assign bit_last  = (mode == FMT_TDM) ? BW'(TD_BITS - 1) : BW'(ST_BITS - 1);
   assign next_bit  = (bitpos == bit_last) ? '0 : bitpos + 1'b1;
   assign bit_end   = (divcnt == div_last);
   assign word_end  = (bitpos[SWW-1:0] == {SWW{1'b1}});
   assign frame_end = bit_end && (bitpos == bit_last);
   assign start     = tx_en && !run;
   assign fault     = run && tx_en && (req_mode != mode) && !frame_end;
   assign load      = start || fault || (run && tx_en && bit_end && word_end);
   assign shift     = run && tx_en && bit_end && !word_end && !fault;

   assign bclk  = run && (divcnt >= div_half);
   assign fsync = run && ((mode == FMT_TDM) ? (bitpos == bit_last) : next_bit[SWW]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         mode   <= FMT_STEREO;
         divcnt <= '0;
         bitpos <= '0;
      end else if (!tx_en) begin
         run    <= 1'b0;
         mode   <= FMT_STEREO;
         divcnt <= '0;
         bitpos <= '0;
      end else if (start || fault) begin
         run    <= 1'b1;
         mode   <= req_mode;
         divcnt <= '0;
         bitpos <= '0;
      end else if (bit_end) begin
         divcnt <= '0;
         bitpos <= next_bit;
         if (frame_end) mode <= req_mode;
      end else begin
         divcnt <= divcnt + 1'b1;
      end
   end
endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx #(
   parameter int SW         = 16,
   parameter int RATIO      = 256,
   parameter int TDM_SLOTS  = 4,
   parameter bit TDM_EN     = 1'b1,
   parameter int FIFO_DEPTH = 8,
   parameter int WM_W       = $clog2(FIFO_DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_en,
   input  logic            tdm_en,
   input  logic            wr_valid,
   input  logic [SW-1:0]   wr_data,
   input  logic [WM_W-1:0] watermark,
   input  logic            fifo_err_clr,
   input  logic            sync_err_clr,
   output logic            bclk,
   output logic            fsync,
   output logic            sdata,
   output logic            dma_req,
   output logic            fifo_full,
   output logic            fifo_empty,
   output logic            word_start,
   output logic            fifo_err,
   output logic            sync_err
);
   localparam int LW = $clog2(FIFO_DEPTH+1);

   generate
      if ((SW & (SW - 1)) != 0 || SW < 2) begin : g_bad_sw
         $error("SW must be a power of two");
      end
      if (RATIO % (2 * SW) != 0 || (RATIO / (2 * SW)) % 2 != 0) begin : g_bad_st
         $error("RATIO must give an even two-channel divider");
      end
      if (TDM_EN && (RATIO % (TDM_SLOTS * SW) != 0 || (RATIO / (TDM_SLOTS * SW)) % 2 != 0)) begin : g_bad_td
         $error("RATIO must give an even network-mode divider");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
   endgenerate

   logic          run, load, shift, fault;
   logic [SW-1:0] head, shreg;
   logic [LW-1:0] level;
   logic          underrun;

   atx_timing #(
      .SW(SW), .RATIO(RATIO), .TDM_SLOTS(TDM_SLOTS), .TDM_EN(TDM_EN)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tdm_en(tdm_en),
      .run(run), .bclk(bclk), .fsync(fsync),
      .load(load), .shift(shift), .fault(fault)
   );

   atx_fifo #(.DW(SW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_valid), .push_data(wr_data),
      .pop(load), .head(head), .level(level),
      .full(fifo_full), .empty(fifo_empty)
   );

   assign underrun = load && fifo_empty;
   assign dma_req  = (level <= LW'(watermark));
   assign sdata    = run && shreg[SW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         word_start <= 1'b0;
         fifo_err   <= 1'b0;
         sync_err   <= 1'b0;
      end else begin
         word_start <= load;
         if (load)       shreg <= fifo_empty ? '0 : head;
         else if (shift) shreg <= {shreg[SW-2:0], 1'b0};
         if (underrun)          fifo_err <= 1'b1;
         else if (fifo_err_clr) fifo_err <= 1'b0;
         if (fault)             sync_err <= 1'b1;
         else if (sync_err_clr) sync_err <= 1'b0;
      end
   end
endmodule

module atx_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic bclk,
   input logic fsync,
   input logic sdata,
   input logic dma_req,
   input logic fifo_full,
   input logic fifo_empty,
   input logic word_start,
   input logic fifo_err,
   input logic fifo_err_clr,
   input logic sync_err,
   input logic sync_err_clr
);
   assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk && $past(bclk)) |-> $stable(sdata));
   assert_full_empty_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));
   assert_req_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> dma_req);
   assert_no_req_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !dma_req);
   assert_word_start_low_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_start |-> !bclk);
   assert_fifo_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_err && !fifo_err_clr) |=> fifo_err);
   assert_sync_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && !sync_err_clr) |=> sync_err);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!bclk && !fsync && !sdata));
endmodule

bind audio_serial_tx atx_checker u_atx_checker (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk(bclk), .fsync(fsync),
   .sdata(sdata), .dma_req(dma_req), .fifo_full(fifo_full),
   .fifo_empty(fifo_empty), .word_start(word_start), .fifo_err(fifo_err),
   .fifo_err_clr(fifo_err_clr), .sync_err(sync_err), .sync_err_clr(sync_err_clr)
);

// File: tb/test_audio_serial_tx.sv
`timescale 1ns/1ps
module test_audio_serial_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0, tdm_en = 1'b0, wr_valid = 1'b0;
   logic [15:0] wr_data = '0;
   logic [2:0]  watermark = 3'd3;
   logic        fifo_err_clr = 1'b0, sync_err_clr = 1'b0;
   logic        bclk, fsync, sdata, dma_req, fifo_full, fifo_empty;
   logic        word_start, fifo_err, sync_err;

   int n_checks = 0, n_errors = 0;
   logic [15:0] words [8];
   logic        cap_sd [256];
   logic        cap_fs [256];
   int          per_bad, first_rise, n_ws;

   always #2.5 clk = ~clk;

   audio_serial_tx i_audio_serial_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tdm_en(tdm_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .watermark(watermark),
      .fifo_err_clr(fifo_err_clr), .sync_err_clr(sync_err_clr),
      .bclk(bclk), .fsync(fsync), .sdata(sdata), .dma_req(dma_req),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .word_start(word_start),
      .fifo_err(fifo_err), .sync_err(sync_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      fifo_err_clr = 1'b1;
      sync_err_clr = 1'b1;
      @(negedge clk);
      fifo_err_clr = 1'b0;
      sync_err_clr = 1'b0;
   endtask

   // Records n bit-clock rising edges, sampled at falling master-clock edges.
   task automatic capture(input int n, input int per);
      int  cyc = 0, last = -1, k = 0;
      logic prev = bclk;
      per_bad = 0; first_rise = -1; n_ws = 0;
      while (k < n) begin
         @(negedge clk);
         cyc++;
         if (word_start) n_ws++;
         if (bclk && !prev) begin
            cap_sd[k] = sdata;
            cap_fs[k] = fsync;
            if (last < 0) first_rise = cyc;
            else if (cyc - last != per) per_bad++;
            last = cyc;
            k++;
         end
         prev = bclk;
      end
   endtask

   task automatic t_reset();
      chk(!bclk && !fsync && !sdata, "R1 lines low", {bclk, fsync, sdata}, 0);
      chk(fifo_empty && !fifo_full, "R1 fifo flags", {fifo_empty, fifo_full}, 2);
      chk(!fifo_err && !sync_err && !word_start, "R1 flags", {fifo_err, sync_err, word_start}, 0);
   endtask

   task automatic t_fifo_fill();
      for (int i = 0; i < 8; i++) words[i] = 16'h8421 + 16'(i) * 16'h1357;
      watermark = 3'd3;
      for (int i = 0; i < 3; i++) push(words[i]);
      chk(dma_req == 1'b1, "R5 level 3 <= wm 3", dma_req, 1);
      push(words[3]);
      chk(dma_req == 1'b0, "R5 level 4 > wm 3", dma_req, 0);
      for (int i = 4; i < 7; i++) push(words[i]);
      watermark = 3'd7;
      @(negedge clk);
      chk(dma_req == 1'b1, "R5 level 7 <= wm 7", dma_req, 1);
      chk(!fifo_full, "R4 not full at 7", fifo_full, 0);
      push(words[7]);
      chk(fifo_full && !fifo_empty, "R4 full at 8", fifo_full, 1);
      chk(dma_req == 1'b0, "R5 level 8 > wm 7", dma_req, 0);
      push(16'hFFFF); // dropped: buffer full
      chk(fifo_full, "R4 still full", fifo_full, 1);
   endtask

   task automatic t_stereo();
      int bad_bits = 0, bad_zero = 0, bad_fs = 0;
      @(negedge clk);
      tx_en = 1'b1;
      capture(160, 8);
      for (int k = 0; k < 160; k++) begin
         logic eb, ef;
         eb = (k < 128) ? words[(k / 32) * 2 + (k % 32) / 16][15 - (k % 16)] : 1'b0;
         ef = (((k + 1) % 32) / 16) == 1;
         if (k < 128 && cap_sd[k] !== eb) bad_bits++;
         if (k >= 128 && cap_sd[k] !== 1'b0) bad_zero++;
         if (cap_fs[k] !== ef) bad_fs++;
      end
      chk(per_bad == 0, "R2 bit clock period 8", per_bad, 0);
      chk(first_rise == 5, "R2 low first half", first_rise, 5);
      chk(bad_bits == 0, "R3 R4 word order and bits", bad_bits, 0);
      chk(bad_fs == 0, "R3 frame sync placement", bad_fs, 0);
      chk(bad_zero == 0, "R7 zeros on underrun", bad_zero, 0);
      chk(n_ws == 10, "R6 word start pulses", n_ws, 10);
      chk(fifo_err, "R7 underrun flag set", fifo_err, 1);
      chk(!sync_err, "R9 no sync error in steady run", sync_err, 0);
      chk(fifo_empty && dma_req, "R4 R5 drained", {fifo_empty, dma_req}, 3);
      @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk(!bclk && !fsync && !sdata, "R10 idle lines", {bclk, fsync, sdata}, 0);
      repeat (5) @(negedge clk);
      chk(fifo_err, "R7 flag sticky", fifo_err, 1);
      pulse_clr();
      chk(!fifo_err, "R7 flag cleared", fifo_err, 0);
   endtask

   task automatic t_tdm();
      int bad_bits = 0, bad_fs = 0;
      for (int i = 0; i < 8; i++) words[i] = 16'hC0DE ^ (16'(i) * 16'h0F31);
      for (int i = 0; i < 8; i++) push(words[i]);
      @(negedge clk);
      tdm_en = 1'b1;
      tx_en  = 1'b1;
      capture(128, 4);
      for (int k = 0; k < 128; k++) begin
         if (cap_sd[k] !== words[(k / 64) * 4 + (k % 64) / 16][15 - (k % 16)]) bad_bits++;
         if (cap_fs[k] !== ((k % 64) == 63)) bad_fs++;
      end
      @(negedge clk);
      tx_en  = 1'b0;
      tdm_en = 1'b0;
      chk(per_bad == 0, "R8 bit clock period 4", per_bad, 0);
      chk(first_rise == 3, "R8 low first half", first_rise, 3);
      chk(bad_bits == 0, "R8 four slots per frame", bad_bits, 0);
      chk(bad_fs == 0, "R8 one-bit sync pulse", bad_fs, 0);
      chk(n_ws == 8, "R6 word start pulses", n_ws, 8);
      chk(!fifo_err && !sync_err, "R7 R9 no false errors", {fifo_err, sync_err}, 0);
   endtask

   task automatic t_sync();
      @(negedge clk);
      tx_en = 1'b1;
      repeat (20) @(negedge clk);
      chk(!sync_err, "R9 no error before change", sync_err, 0);
      tdm_en = 1'b1;
      @(negedge clk);
      chk(sync_err, "R9 mid-frame change flagged", sync_err, 1);
      capture(3, 4);
      chk(per_bad == 0 && first_rise == 2, "R9 restart in new format", first_rise, 2);
      @(negedge clk);
      tx_en  = 1'b0;
      tdm_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(sync_err, "R9 flag sticky", sync_err, 1);
      pulse_clr();
      chk(!sync_err && !fifo_err, "R9 flag cleared", {sync_err, fifo_err}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fifo_fill();
      t_stereo();
      t_tdm();
      t_sync();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule